// File: doc/BRIEF.md
# Reloadable Down-Counting Event Counter

This block is one channel of a timer that counts events rather than clock cycles. Each qualifying event lowers a 16-bit counter by one. An event is either a selected edge of an external input pin, or a pulse from a neighbouring timer channel that marks its own overflow or underflow. When an event finds the counter at zero, the counter reloads from a reload register and the block raises a single-cycle interrupt request. A programmed value n therefore divides the event rate by n+1.

Software controls the channel through three things: a counter write strobe, a mode register write strobe and a level start flag. A counter write while the channel is halted sets the counter and the reload register together. While the channel is running, the same write changes only the reload register, and the counter takes that value at its next reload. The pin is asynchronous to the system clock. It passes through a synchroniser before edge detection.

Top module: `evt_down_counter`

## Requirements
- R1: After reset the counter, the reload register, the mode register and the interrupt request are all zero.
- R2: Each qualifying event decrements the counter by one. An event that finds the counter at 0 loads the reload value instead, so a reload value n gives one underflow every n+1 events.
- R3: On an underflow, `irq` is high for exactly one cycle, in the cycle after the event is accepted. In that same cycle `cnt_q` already shows the reloaded value.
- R4: Mode bits [3:2] choose the pin edges that count: 00 falling edges, 01 rising edges, 10 both edges. The value 11 counts no pin edges.
- R5: Mode bit 4 chooses the event source: 0 selects the pin, 1 selects `nbr_tick`. When bit 4 is 1, bits [3:2] have no effect, and pin edges are ignored. When bit 4 is 0, `nbr_tick` is ignored.
- R6: While `run_en` is 0, events do not change the counter.
- R7: A counter write while `run_en` is 0 sets both the counter and the reload register to `wr_data`. `cnt_q` shows the value in the next cycle.
- R8: A counter write while `run_en` is 1 changes only the reload register. The counter keeps counting down, and it loads the new value at the next underflow.
- R9: When a counter write and an underflow happen in the same cycle, the counter loads the written value and `irq` is still raised.
- R10: Mode bits [1:0] must be 01 for events to count. With any other value, all events are ignored. `mode_q` reads back the five stored mode bits.
- R11: A pin edge reaches the counter through a two-stage synchroniser. `cnt_q` changes on the third rising clock edge after the pin changes, and each pin edge counts at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pin | input | 1 | External event input, asynchronous |
| nbr_tick | input | 1 | One-cycle overflow/underflow pulse from the neighbouring channel |
| run_en | input | 1 | Start flag: 1 counts, 0 halts |
| wr_cnt | input | 1 | Counter register write strobe |
| wr_data | input | 16 | Counter register write value |
| wr_mode | input | 1 | Mode register write strobe |
| mode_data | input | 5 | Mode value: [1:0] operation, [3:2] edge select, [4] source |
| cnt_q | output | 16 | Live counter value |
| mode_q | output | 5 | Stored mode value |
| irq | output | 1 | One-cycle underflow interrupt request |

## Verification
The bench builds the block with the default 16-bit counter and a two-stage synchroniser. Counter writes are mostly small values, so underflows, reloads and the write-at-underflow collision come up often, even with a full-width counter. The fixed synchroniser depth lets the bench pin down the three-edge pin latency exactly. Random sequences mix both event sources, all four edge settings, mode values with a wrong operation field, and start/stop changes.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int MODE_W = 5;
  localparam logic [1:0] OP_EVENT = 2'b01;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      src_nbr;
    edge_sel_e edge_sel;
    logic [1:0] op;
  } mode_t;
endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;
  logic              sync_out;

  assign sync_out = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    last_d = sync_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_out & ~last_q;
  assign fall_o = ~sync_out & last_q;

  // R11: one pin transition yields at most one detected edge per cycle
  p_single_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
  // R11: a detected rising edge cannot repeat in the following cycle
  p_edge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_cnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_i,
  input  logic  run_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  nbr_i,
  output logic  evt_o
);
  logic pin_hit;
  logic src_hit;

  always_comb begin
    unique case (mode_i.edge_sel)
      EDGE_FALL: pin_hit = fall_i;
      EDGE_RISE: pin_hit = rise_i;
      EDGE_BOTH: pin_hit = rise_i | fall_i;
      default:   pin_hit = 1'b0;
    endcase
    src_hit = mode_i.src_nbr ? nbr_i : pin_hit;
    evt_o   = run_i && (mode_i.op == OP_EVENT) && src_hit;
  end

  // R10: a wrong operation field never lets an event through
  p_bad_op_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.op != OP_EVENT) |-> !evt_o);
  // R5: with the neighbour source, pin edges alone never produce an event
  p_nbr_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i.src_nbr && !nbr_i) |-> !evt_o);
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             irq_q, irq_d;
  logic             uflow;
  logic             rld_en, cnt_en;

  always_comb begin
    uflow  = evt_i && (cnt_q == '0);
    rld_en = wr_i;
    rld_d  = wdata_i;
    cnt_en = (wr_i && !run_i) || evt_i;
    cnt_d  = cnt_q;
    irq_d  = uflow;
    if (wr_i && !run_i) begin
      cnt_d = wdata_i;
    end else if (uflow) begin
      cnt_d = wr_i ? wdata_i : rld_q;
    end else if (evt_i) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rld_en) rld_q <= rld_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R6: halted and not written, the counter holds
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_i) |=> $stable(cnt_q));
  // R7: a write while halted lands in the counter
  p_stopped_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !run_i) |=> (cnt_q == $past(wdata_i)));
  // R2: an event on a nonzero count lowers it by one
  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - ONE));
  // R3: an event at zero raises the request in the next cycle
  p_uflow_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && (cnt_q == '0)) |=> irq_o);
  // R9: a write colliding with underflow is taken by the counter
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && wr_i && run_i && (cnt_q == '0)) |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_pin,
  input  logic              nbr_tick,
  input  logic              run_en,
  input  logic              wr_cnt,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wr_mode,
  input  logic [MODE_W-1:0] mode_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              irq
);
  mode_t mode_r, mode_d;
  logic  pin_rise, pin_fall;
  logic  evt;

  always_comb begin
    mode_d = mode_r;
    if (wr_mode) mode_d = mode_t'(mode_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_r <= '0;
    else if (wr_mode) mode_r <= mode_d;
  end

  assign mode_q = mode_r;

  evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ev_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  evt_qualify u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_r),
    .run_i  (run_en),
    .rise_i (pin_rise),
    .fall_i (pin_fall),
    .nbr_i  (nbr_tick),
    .evt_o  (evt)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_en),
    .evt_i   (evt),
    .wr_i    (wr_cnt),
    .wdata_i (wr_data),
    .cnt_o   (cnt_q),
    .irq_o   (irq)
  );

  // R10: the mode readback follows a mode write
  p_mode_rb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_q == $past(mode_data)));
endmodule

// File: tb/evt_down_counter_tb.sv
`timescale 1ns/1ps
module evt_down_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_pin, nbr_tick, run_en, wr_cnt, wr_mode;
  logic [15:0] wr_data;
  logic [4:0]  mode_data;
  logic [15:0] cnt_q;
  logic [4:0]  mode_q;
  logic        irq;

  int checks = 0, errors = 0, irq_seen = 0;
  bit done = 0;
  logic [15:0] m_cnt, m_rld;
  logic [4:0]  m_mode;
  int          m_irqs;

  always #2 clk = ~clk;

  evt_down_counter u_dut (
    .clk(clk), .rst_n(rst_n), .ev_pin(ev_pin), .nbr_tick(nbr_tick),
    .run_en(run_en), .wr_cnt(wr_cnt), .wr_data(wr_data), .wr_mode(wr_mode),
    .mode_data(mode_data), .cnt_q(cnt_q), .mode_q(mode_q), .irq(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic bit counts_pin(bit rise);
    if (!run_en || m_mode[1:0] != 2'b01 || m_mode[4]) return 0;
    case (m_mode[3:2])
      2'b00: return !rise;
      2'b01: return rise;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit counts_nbr();
    return run_en && m_mode[1:0] == 2'b01 && m_mode[4];
  endfunction

  task automatic model_event();
    if (m_cnt == 0) begin m_cnt = m_rld; m_irqs++; end
    else m_cnt = m_cnt - 1;
  endtask

  task automatic set_mode(logic [4:0] m);
    wr_mode = 1; mode_data = m; @(negedge clk); wr_mode = 0; m_mode = m;
  endtask

  task automatic do_write(logic [15:0] v);
    wr_cnt = 1; wr_data = v; @(negedge clk); wr_cnt = 0;
    m_rld = v;
    if (!run_en) m_cnt = v;
  endtask

  task automatic tick();
    nbr_tick = 1; @(negedge clk); nbr_tick = 0;
    if (counts_nbr()) model_event();
  endtask

  task automatic toggle();
    bit r;
    ev_pin = ~ev_pin; r = ev_pin;
    repeat (4) @(negedge clk);
    if (counts_pin(r)) model_event();
  endtask

  task automatic set_run(logic r);
    run_en = r; @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 0; ev_pin = 0; nbr_tick = 0; run_en = 0; wr_cnt = 0;
    wr_mode = 0; wr_data = 0; mode_data = 0;
    m_cnt = 0; m_rld = 0; m_mode = 0; m_irqs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);

    // R1 reset state
    chk("R1 cnt", cnt_q, 0); chk("R1 mode", mode_q, 0); chk("R1 irq", irq, 0);

    // R10 readback, neighbour source
    set_mode(5'b10001);
    chk("R10 mode readback", mode_q, 5'b10001);
    do_write(16'd3);
    chk("R7 stopped write", cnt_q, 3);
    set_run(1);
    repeat (3) tick();
    chk("R2 decrement to zero", cnt_q, 0);
    tick();
    chk("R2 reload after n+1", cnt_q, 3);
    chk("R3 irq high", irq, 1);
    @(negedge clk);
    chk("R3 irq one cycle", irq, 0);

    // R8 running write
    do_write(16'd7);
    chk("R8 counter untouched", cnt_q, 3);
    repeat (4) tick();
    chk("R8 new value at reload", cnt_q, 7);

    // R9 collision
    repeat (7) tick();
    chk("R9 at zero", cnt_q, 0);
    nbr_tick = 1; wr_cnt = 1; wr_data = 16'd9;
    @(negedge clk);
    nbr_tick = 0; wr_cnt = 0; m_rld = 9; m_cnt = 9; m_irqs++;
    chk("R9 counter takes written value", cnt_q, 9);
    chk("R9 irq", irq, 1);

    // R6 halt
    set_run(0);
    tick(); tick();
    chk("R6 halted", cnt_q, 9);
    set_run(1);

    // R5 polarity ignored on neighbour source
    set_mode(5'b11101);
    tick();
    chk("R5 nbr with edge 11", cnt_q, 8);
    toggle(); toggle();
    chk("R5 pin ignored", cnt_q, 8);

    // R4 edges, R5 tick ignored on pin source
    set_mode(5'b00101);
    tick();
    chk("R5 tick ignored", cnt_q, 8);
    // R11 latency: pin goes high
    ev_pin = 1;
    @(negedge clk); @(negedge clk);
    chk("R11 not yet", cnt_q, 8);
    @(negedge clk);
    chk("R11 third edge", cnt_q, 7);
    repeat (2) @(negedge clk);
    chk("R11 counted once", cnt_q, 7);
    m_cnt = 7;
    toggle();
    chk("R4 rising ignores fall", cnt_q, 7);
    set_mode(5'b00001);
    toggle(); toggle();
    chk("R4 falling", cnt_q, 6);
    set_mode(5'b01001);
    toggle(); toggle();
    chk("R4 both", cnt_q, 4);
    set_mode(5'b01101);
    toggle(); toggle();
    chk("R4 edge 11 none", cnt_q, 4);

    // R10 wrong op
    set_mode(5'b10010);
    tick(); tick();
    chk("R10 op 10 idle", cnt_q, 4);
    set_mode(5'b01000);
    toggle();
    chk("R10 op 00 idle", cnt_q, 4);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) tick();
      else if (op < 6) toggle();
      else if (op == 6) do_write(16'($urandom_range(0, 5)));
      else if (op == 7) set_mode({1'($urandom_range(0,1)), 2'($urandom_range(0,3)),
                                  ($urandom_range(0,5) == 0) ? 2'b11 : 2'b01});
      else if (op == 8) set_run(($urandom_range(0, 3) != 0));
      else @(negedge clk);
      if (m_cnt != cnt_q || (i % 50) == 0)
        chk("R2 random count", cnt_q, m_cnt);
    end
    @(negedge clk);
    chk("R3 irq total", irq_seen, m_irqs);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule